// File: doc/BRIEF.md
# Banked GPIO Controller with Shared Interrupt

This block is a memory-mapped general-purpose I/O peripheral organised as a configurable number of banks (three by default), each 32 pins wide. A simple single-cycle register bus lets software pick the direction of each pin and drive outputs. Outputs can be rewritten as a whole word, or individual bits can be raised or lowered through dedicated set and clear registers, so that no read-modify-write is needed. Incoming pad levels pass through a two-stage synchroniser before they are read back or examined for events.

Each pin has four independent event sense enables: rising edge, falling edge, high level and low level. A per-pin polarity bit can invert the input before event detection. Detected events latch into a per-bank status register that software clears by writing ones. A companion register records which latched bits came from an edge. One interrupt output, shared by every bank, stays high while any status bit anywhere is set.

Top module: `pinbank_gpio`

## Requirements
- R1: After reset every register reads zero, pad_oe and pad_out are all zero and irq is low.
- R2: Register address = group base + 4 × bank, with group bases direction 0x00, polarity 0x10, data 0x20, set 0x30, clear 0x40, rising enable 0x50, falling enable 0x60, high-level enable 0x70, low-level enable 0x80, status 0x90, edge 0xA0. Global pin p lies in bank p/32, bit p%32. Set and clear read as zero, and unmapped or misaligned offsets (including a bank index beyond the last bank) read zero.
- R3: Direction bit 1 makes the pin an output (pad_oe bit high) and 0 an input. A read of the data register returns the driven value for outputs and the synchronised pad level for inputs.
- R4: A data write replaces the driven values. A one in a set-register write drives that bit high, a one in a clear-register write drives it low, and zero bits leave outputs unchanged.
- R5: A pad change appears in a data-register read after exactly two rising clock edges.
- R6: With the rising enable set, a low-to-high change of the polarity-adjusted input sets the status bit on the third rising edge after the pad change and not earlier. The same edge is ignored if the enable is clear.
- R7: The falling enable detects high-to-low changes. With both edge enables set, either direction sets the status bit.
- R8: A high-level or low-level enable sets the status bit on every clock while the level persists. A clearing write then has no lasting effect, and the bit stays clear once the level is gone.
- R9: Polarity bit 1 inverts the input before event detection, so that a high-level enable fires on a low pad. Polarity 0 leaves the input uninverted.
- R10: Writing a one to a status bit clears it and the matching edge bit, and zero bits have no effect. An edge bit is set only for status bits caused by an edge event, not by a level event. An event in the same cycle as a clear wins.
- R11: irq is high exactly while some status bit in some bank is set. With all four enables of every pin clear, no status bit is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Write strobe, sampled on the rising edge |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| pad_in | input | 96 | Raw pad input levels, pin p at bit p |
| pad_out | output | 96 | Driven output values |
| pad_oe | output | 96 | Output enable per pin (direction) |
| irq | output | 1 | Shared interrupt, high while any status bit is set |

## Verification
The bench builds the block with its default three banks of 32 pins. This makes the last bank index and the first missing bank index at offset 0x0C both reachable, and exercises all eleven register groups of each bank. Random direction, data, set and clear traffic runs against random static pad levels with every sense enable off, which also confirms that a fully masked pin never raises irq. Directed sequences then check the exact cycle of synchroniser and status timing, the re-assertion of level events, the inversion by polarity and the partial write-one-to-clear of status.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  // Register groups; the value times 16 is the group's base offset.
  typedef enum logic [3:0] {
    GRP_DIR  = 4'd0,
    GRP_POL  = 4'd1,
    GRP_DATA = 4'd2,
    GRP_DSET = 4'd3,
    GRP_DCLR = 4'd4,
    GRP_REN  = 4'd5,
    GRP_FEN  = 4'd6,
    GRP_HEN  = 4'd7,
    GRP_LEN  = 4'd8,
    GRP_STAT = 4'd9,
    GRP_EDGE = 4'd10
  } reg_grp_e;

  localparam int GROUP_SPAN  = 16;
  localparam int BANK_STRIDE = 4;

  // Byte offset of one bank's register within a group.
  function automatic int reg_offset(input reg_grp_e grp, input int bank);
    return int'(grp) * GROUP_SPAN + bank * BANK_STRIDE;
  endfunction

  // Next status word: clear by write-one, then OR new events (events win).
  function automatic logic [31:0] w1c_merge(input logic [31:0] cur,
                                            input logic [31:0] clr,
                                            input logic [31:0] ev);
    return (cur & ~clr) | ev;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 96
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_in;
      stage2_q <= stage1_q;
    end
  end

  assign d_sync = stage2_q;
endmodule

// File: rtl/gpio_event_detect.sv
module gpio_event_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] smp,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic [W-1:0] high_en,
  input  logic [W-1:0] low_en,
  output logic [W-1:0] ev_edge,
  output logic [W-1:0] ev_level
);
  logic [W-1:0] adj, adj_prev_q, rose, fell;

  assign adj = smp ^ pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) adj_prev_q <= '0;
    else        adj_prev_q <= adj;
  end

  assign rose     = adj & ~adj_prev_q;
  assign fell     = ~adj & adj_prev_q;
  assign ev_edge  = (rose & rise_en) | (fell & fall_en);
  assign ev_level = (adj & high_en) | (~adj & low_en);
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_pkg::*;
#(
  parameter int BANK_IDX = 0,
  parameter int W        = 32,
  parameter int ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      smp,
  input  logic [W-1:0]      ev_edge,
  input  logic [W-1:0]      ev_level,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      out_q,
  output logic [W-1:0]      pol_q,
  output logic [W-1:0]      ren_q,
  output logic [W-1:0]      fen_q,
  output logic [W-1:0]      hen_q,
  output logic [W-1:0]      len_q,
  output logic [W-1:0]      stat_q,
  output logic [W-1:0]      edge_q,
  output logic [W-1:0]      rdata
);
  localparam int NGRP = 11;

  logic [NGRP-1:0] hit;
  logic [W-1:0]    stat_clr;

  for (genvar g = 0; g < NGRP; g++) begin : g_dec
    assign hit[g] = (int'(addr) == reg_offset(reg_grp_e'(g), BANK_IDX));
  end

  assign stat_clr = (wr_en && hit[GRP_STAT]) ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0; out_q <= '0; pol_q <= '0;
      ren_q <= '0; fen_q <= '0; hen_q <= '0; len_q <= '0;
      stat_q <= '0; edge_q <= '0;
    end else begin
      if (wr_en && hit[GRP_DIR]) dir_q <= wdata;
      if (wr_en && hit[GRP_POL]) pol_q <= wdata;
      if (wr_en && hit[GRP_REN]) ren_q <= wdata;
      if (wr_en && hit[GRP_FEN]) fen_q <= wdata;
      if (wr_en && hit[GRP_HEN]) hen_q <= wdata;
      if (wr_en && hit[GRP_LEN]) len_q <= wdata;
      if (wr_en && hit[GRP_DATA])      out_q <= wdata;
      else if (wr_en && hit[GRP_DSET]) out_q <= out_q | wdata;
      else if (wr_en && hit[GRP_DCLR]) out_q <= out_q & ~wdata;
      stat_q <= w1c_merge(stat_q, stat_clr, ev_edge | ev_level);
      edge_q <= w1c_merge(edge_q, stat_clr, ev_edge);
    end
  end

  always_comb begin
    rdata = '0;
    if (hit[GRP_DIR])  rdata = dir_q;
    if (hit[GRP_POL])  rdata = pol_q;
    if (hit[GRP_DATA]) rdata = (dir_q & out_q) | (~dir_q & smp);
    if (hit[GRP_REN])  rdata = ren_q;
    if (hit[GRP_FEN])  rdata = fen_q;
    if (hit[GRP_HEN])  rdata = hen_q;
    if (hit[GRP_LEN])  rdata = len_q;
    if (hit[GRP_STAT]) rdata = stat_q;
    if (hit[GRP_EDGE]) rdata = edge_q;
  end
endmodule

// File: rtl/pinbank_gpio.sv
module pinbank_gpio
  import gpio_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_wr_en,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [BANK_W-1:0]             reg_wdata,
  output logic [BANK_W-1:0]             reg_rdata,
  input  logic [NUM_BANKS*BANK_W-1:0]   pad_in,
  output logic [NUM_BANKS*BANK_W-1:0]   pad_out,
  output logic [NUM_BANKS*BANK_W-1:0]   pad_oe,
  output logic                          irq
);
  localparam int NPINS = NUM_BANKS * BANK_W;

  logic [NPINS-1:0]  smp_all;
  logic [NPINS-1:0]  ev_edge_all, ev_level_all, ev_set_all;
  logic [NPINS-1:0]  stat_all, edge_all;
  logic [BANK_W-1:0] rd_bank [NUM_BANKS];

  gpio_sync #(.W(NPINS)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_in(pad_in), .d_sync(smp_all)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [BANK_W-1:0] pol, ren, fen, hen, len;

    gpio_bank_regs #(.BANK_IDX(b), .W(BANK_W), .ADDR_W(ADDR_W)) regs_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
      .smp(smp_all[b*BANK_W +: BANK_W]),
      .ev_edge(ev_edge_all[b*BANK_W +: BANK_W]),
      .ev_level(ev_level_all[b*BANK_W +: BANK_W]),
      .dir_q(pad_oe[b*BANK_W +: BANK_W]),
      .out_q(pad_out[b*BANK_W +: BANK_W]),
      .pol_q(pol), .ren_q(ren), .fen_q(fen), .hen_q(hen), .len_q(len),
      .stat_q(stat_all[b*BANK_W +: BANK_W]),
      .edge_q(edge_all[b*BANK_W +: BANK_W]),
      .rdata(rd_bank[b])
    );

    gpio_event_detect #(.W(BANK_W)) det_i (
      .clk(clk), .rst_n(rst_n),
      .smp(smp_all[b*BANK_W +: BANK_W]),
      .pol(pol), .rise_en(ren), .fall_en(fen), .high_en(hen), .low_en(len),
      .ev_edge(ev_edge_all[b*BANK_W +: BANK_W]),
      .ev_level(ev_level_all[b*BANK_W +: BANK_W])
    );
  end

  assign ev_set_all = ev_edge_all | ev_level_all;

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) reg_rdata = reg_rdata | rd_bank[b];
  end

  assign irq = |stat_all;
endmodule

// File: rtl/pinbank_gpio_chk.sv
module pinbank_gpio_chk #(
  parameter int N = 96
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [N-1:0] ev_set,
  input logic [N-1:0] stat,
  input logic [N-1:0] edge_bits,
  input logic [N-1:0] pad_out,
  input logic         irq
);
  // R6
  event_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & $past(ev_set)) == $past(ev_set)));

  // R11
  status_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & ~$past(stat) & ~$past(ev_set)) == '0));

  // R11
  irq_matches_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (stat != '0));

  // R10
  edge_within_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_bits & ~stat) == '0);

  // R4
  outputs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(pad_out));
endmodule

bind pinbank_gpio pinbank_gpio_chk #(.N(NUM_BANKS*BANK_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en),
  .ev_set(ev_set_all), .stat(stat_all), .edge_bits(edge_all),
  .pad_out(pad_out), .irq(irq)
);

// File: tb/pinbank_gpio_tb_top.sv
module pinbank_gpio_tb_top;
  localparam int NB = 3;
  localparam int BW = 32;
  localparam int NP = NB * BW;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          reg_wr_en = 0;
  logic [7:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;
  logic          irq;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_dir [NB];
  logic [31:0] m_out [NB];

  always #2 clk = ~clk;

  pinbank_gpio dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  // Bench's own address arithmetic: 0x10 per group, 4 per bank.
  function automatic int off(input int grp, input int bank);
    return grp * 'h10 + bank * 4;
  endfunction

  function automatic logic [31:0] exp_data(input int b);
    return (m_dir[b] & m_out[b]) | (~m_dir[b] & pad_in[b*BW +: BW]);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    reg_wr_en = 1; reg_addr = a[7:0]; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr = a[7:0];
    #1 d = reg_rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(1234));
    for (int b = 0; b < NB; b++) begin m_dir[b] = '0; m_out[b] = '0; end
    wait_n(3);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    for (int g = 0; g < 11; g++)
      for (int b = 0; b < NB; b++) begin
        rd(off(g, b), v);
        chk("R1 reset reg", v, 32'h0);
      end
    chk("R1 pad_oe", pad_oe[31:0] | pad_oe[63:32] | pad_oe[95:64], 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R2: unmapped, misaligned, missing bank, write-only groups
    wr(off(3, 1), 32'h0000_00ff);
    m_out[1] = 32'h0000_00ff;
    rd('hB0, v); chk("R2 unmapped 0xB0", v, 0);
    rd('h0C, v); chk("R2 missing bank", v, 0);
    rd('h21, v); chk("R2 misaligned", v, 0);
    rd(off(3, 1), v); chk("R2 set reads zero", v, 0);
    rd(off(4, 1), v); chk("R2 clear reads zero", v, 0);

    // R3/R4/R11: random output traffic, all sense enables off
    pad_in = {$urandom, $urandom, $urandom};
    wait_n(3);
    for (int i = 0; i < 300; i++) begin
      int b, sel;
      logic [31:0] d;
      b = $urandom_range(0, NB - 1);
      sel = $urandom_range(0, 3);
      d = $urandom;
      case (sel)
        0: begin wr(off(0, b), d); m_dir[b] = d; end
        1: begin wr(off(2, b), d); m_out[b] = d; end
        2: begin wr(off(3, b), d); m_out[b] |= d; end
        default: begin wr(off(4, b), d); m_out[b] &= ~d; end
      endcase
      chk("R4 pad_out", pad_out[b*BW +: BW], m_out[b]);
      chk("R3 pad_oe", pad_oe[b*BW +: BW], m_dir[b]);
      rd(off(2, b), v);
      chk("R3 data read", v, exp_data(b));
      chk("R11 masked irq", {31'h0, irq}, 0);
    end

    // R5: synchroniser latency
    pad_in = '0;
    for (int b = 0; b < NB; b++) begin wr(off(0, b), 0); m_dir[b] = 0; end
    wait_n(3);
    pad_in[15] = 1'b1;
    wait_n(1);
    rd(off(2, 0), v); chk("R5 one edge old", v & 32'h8000, 0);
    wait_n(1);
    rd(off(2, 0), v); chk("R5 two edges new", v & 32'h8000, 32'h8000);

    // R6: rising edge timing on bank 1 bit 3
    pad_in[32+4] = 1'b1;   // edge with no enable: ignored
    wait_n(4);
    rd(off(9, 1), v); chk("R6 no enable ignored", v, 0);
    wr(off(5, 1), 32'h8);
    pad_in[32+3] = 1'b1;
    wait_n(2);
    rd(off(9, 1), v); chk("R6 not before third edge", v, 0);
    wait_n(1);
    rd(off(9, 1), v); chk("R6 status set", v, 32'h8);
    rd(off(10, 1), v); chk("R10 edge bit set", v, 32'h8);
    chk("R11 irq high", {31'h0, irq}, 1);
    wr(off(9, 1), 32'h8);
    rd(off(9, 1), v); chk("R10 status cleared", v, 0);
    rd(off(10, 1), v); chk("R10 edge cleared", v, 0);
    chk("R11 irq low", {31'h0, irq}, 0);

    // R7: falling and both edges
    pad_in[32+3] = 1'b0;
    wait_n(4);
    rd(off(9, 1), v); chk("R7 fall without enable", v, 0);
    wr(off(6, 1), 32'h8);
    pad_in[32+3] = 1'b1;
    wait_n(3);
    rd(off(9, 1), v); chk("R7 both: rise", v, 32'h8);
    wr(off(9, 1), 32'h8);
    pad_in[32+3] = 1'b0;
    wait_n(3);
    rd(off(9, 1), v); chk("R7 both: fall", v, 32'h8);
    wr(off(9, 1), 32'h8);

    // R10: partial write-one-to-clear on bank 2
    wr(off(5, 2), 32'h3);
    pad_in[64 +: 2] = 2'b11;
    wait_n(3);
    rd(off(9, 2), v); chk("R10 two bits set", v, 32'h3);
    wr(off(9, 2), 32'h0);
    rd(off(9, 2), v); chk("R10 zero write no effect", v, 32'h3);
    wr(off(9, 2), 32'h1);
    rd(off(9, 2), v); chk("R10 partial clear", v, 32'h2);
    rd(off(10, 2), v); chk("R10 partial edge clear", v, 32'h2);
    wr(off(9, 2), 32'h2);

    // R8: high level persists through clear
    wr(off(7, 0), 32'h80);
    pad_in[7] = 1'b1;
    wait_n(3);
    rd(off(9, 0), v); chk("R8 high level set", v, 32'h80);
    rd(off(10, 0), v); chk("R10 level not edge", v, 0);
    wr(off(9, 0), 32'h80);
    rd(off(9, 0), v); chk("R8 clear has no lasting effect", v, 32'h80);
    pad_in[7] = 1'b0;
    wait_n(3);
    wr(off(9, 0), 32'h80);
    rd(off(9, 0), v); chk("R8 gone after level drops", v, 0);

    // R8: low level on an already-low pad (bank 0 bit 8)
    wr(off(8, 0), 32'h100);
    wait_n(1);
    rd(off(9, 0), v); chk("R8 low level set", v, 32'h100);
    wr(off(8, 0), 32'h0);
    wr(off(9, 0), 32'h100);
    rd(off(9, 0), v); chk("R8 low cleared after disable", v, 0);

    // R9: polarity inverts before detection (bank 2 bit 9, pad low)
    wr(off(7, 2), 32'h200);
    wait_n(2);
    rd(off(9, 2), v); chk("R9 pol 0 no event", v, 0);
    wr(off(1, 2), 32'h200);
    wait_n(1);
    rd(off(9, 2), v); chk("R9 inverted level fires", v, 32'h200);
    pad_in[64+9] = 1'b1;
    wait_n(3);
    wr(off(9, 2), 32'h200);
    rd(off(9, 2), v); chk("R9 high pad inverted quiet", v, 0);
    chk("R11 irq low at end", {31'h0, irq}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule